// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog that software arms by picking a timeout from a fixed table of interval codes. Every write that changes its setup must carry a key in its upper bits. While it is enabled, the block counts half-millisecond ticks. The counter starts again from zero on each properly keyed restart command. If software stops sending restarts, the counter reaches the selected period. The block then either fires a one-cycle system-reset pulse or raises a sticky interrupt, depending on the configuration register.

The register interface is a plain 32-bit port with address, write enable, write data, read enable and read data. Reads are combinational while `rd_en` is high. The parameter `CLKS_PER_HALF_MS` sets how many clocks make one half-millisecond tick. A timeout of S seconds therefore lasts `S * 2000 * CLKS_PER_HALF_MS` clock cycles from the edge on which the counter restarts.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is disabled, with interval code 0 and action 1 (system reset), and both `sys_rst_pulse` and `irq` are low.
- R2: A write to offset 0x18 (mode) updates the enable bit (bit 0) and the interval code (bits 7:4) only when bits 31:16 hold 0x16AA; without that key the mode is unchanged.
- R3: A write to offset 0x14 (action) updates the action field (bits 1:0) only when bits 31:16 hold 0x16AA; without that key the action is unchanged.
- R4: A write to offset 0x10 restarts the counter and clears `irq` only when bit 0 is 1 and bits 12:1 hold 0xA57; any other value has no effect.
- R5: Interval codes 0 to 11 give 0.5, 1, 2, 3, 4, 5, 6, 8, 10, 12, 14 and 16 s; the expiry output rises T·2000·CLKS_PER_HALF_MS cycles after the restart edge.
- R6: Interval codes 12 to 15 behave as code 11 (16 s).
- R7: With action 1, each expiry gives `sys_rst_pulse` high for exactly one cycle, and the count then runs again from zero, so the next pulse follows one period later.
- R8: With action 2, expiry sets `irq`, which stays high until a valid keyed restart, and `sys_rst_pulse` stays low.
- R9: While the enable bit is clear, the counter does not advance and no expiry occurs.
- R10: The counter restarts from zero when a keyed mode write enables the block or changes the interval code while it is enabled.
- R11: A read of offset 0x18 returns {24'b0, code, 3'b0, enable}; a read of 0x14 returns the action in bits 1:0; every key field and offset 0x10 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_data | input | 32 | Write data including key fields |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, zero when `rd_en` is low |
| sys_rst_pulse | output | 1 | One-cycle system reset request on expiry |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
The hardest case to produce from the ports is a restart that fails: a control write with a wrong key, or with the right key and bit 0 clear, arriving partway through a count. Its only visible effect would be a shift in the time of the next expiry. The bench places such writes in the middle of a period and then requires the pulse to land on the exact cycle counted from the earlier enable. After that it sends a valid restart and requires the next pulse to move by exactly the time elapsed. A code change made 1500 cycles into a 2000-cycle count is timed the same way, as is the clearing of a sticky interrupt that has already survived a full wrap of the counter.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CLKS_PER_HALF_MS = 24000,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              sys_rst_pulse,
  output logic              irq
);
  localparam int PRE_W = (CLKS_PER_HALF_MS > 1) ? $clog2(CLKS_PER_HALF_MS) : 1;
  localparam int TICKS_PER_UNIT = 1000;
  localparam int CNT_W = $clog2(32 * TICKS_PER_UNIT + 1);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] OFS_ACT  = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(24);
  localparam logic [11:0] RESTART_KEY = 12'hA57;
  localparam logic [15:0] SETUP_KEY   = 16'h16AA;
  localparam logic [1:0]  ACT_RESET   = 2'd1;
  localparam logic [1:0]  ACT_IRQ     = 2'd2;

  logic             en;
  logic [3:0]       code;
  logic [1:0]       act;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic ctrl_wr, restart, mode_wr, act_wr, mode_restart, tick, expire;

  function automatic logic [5:0] half_sec_units(input logic [3:0] c);
    case (c)
      4'd0: return 6'd1;   4'd1: return 6'd2;   4'd2: return 6'd4;
      4'd3: return 6'd6;   4'd4: return 6'd8;   4'd5: return 6'd10;
      4'd6: return 6'd12;  4'd7: return 6'd16;  4'd8: return 6'd20;
      4'd9: return 6'd24;  4'd10: return 6'd28;
      default: return 6'd32;
    endcase
  endfunction

  assign ctrl_wr      = wr_en && addr == OFS_CTRL;
  assign restart      = ctrl_wr && wr_data[0] && wr_data[12:1] == RESTART_KEY;
  assign mode_wr      = wr_en && addr == OFS_MODE && wr_data[31:16] == SETUP_KEY;
  assign act_wr       = wr_en && addr == OFS_ACT && wr_data[31:16] == SETUP_KEY;
  assign mode_restart = mode_wr && wr_data[0] && (!en || wr_data[7:4] != code);
  assign limit        = CNT_W'(int'(half_sec_units(code)) * TICKS_PER_UNIT);
  assign tick         = pre == PRE_W'(CLKS_PER_HALF_MS - 1);
  assign expire       = en && tick && cnt == limit - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      code <= 4'd0;
      act <= ACT_RESET;
      pre <= '0;
      cnt <= '0;
      sys_rst_pulse <= 1'b0;
      irq <= 1'b0;
    end else begin
      sys_rst_pulse <= expire && act == ACT_RESET;
      if (mode_wr) begin
        en <= wr_data[0];
        code <= wr_data[7:4];
      end
      if (act_wr) act <= wr_data[1:0];
      if (restart) irq <= 1'b0;
      else if (expire && act == ACT_IRQ) irq <= 1'b1;
      if (!en || restart || mode_restart || expire) begin
        pre <= '0;
        cnt <= '0;
      end else if (tick) begin
        pre <= '0;
        cnt <= cnt + CNT_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == OFS_MODE) rd_data = {24'b0, code, 3'b0, en};
      else if (addr == OFS_ACT) rd_data = {30'b0, act};
    end
  end

  p_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MODE && wr_data[31:16] != SETUP_KEY) |=> ($stable(en) && $stable(code)));
  p_act_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ACT && wr_data[31:16] != SETUP_KEY) |=> $stable(act));
  p_bad_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[12:1] != RESTART_KEY && irq) |=> irq);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);
  p_pulse_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_pulse) |-> $past(act) == ACT_RESET);
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !restart) |=> irq);
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !irq) |=> (!sys_rst_pulse && !irq));
endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_MS_CLKS = 1;
  localparam int UNIT = 1000 * HALF_MS_CLKS;
  localparam logic [31:0] MKEY = 32'h16AA0000;
  localparam logic [31:0] RESTART = 32'h000014AF;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic sys_rst_pulse, irq;
  int cyc = 0, nchk = 0, nerr = 0, pcount = 0, t_wr = 0;
  bit done = 0;

  keyed_wdt #(.CLKS_PER_HALF_MS(HALF_MS_CLKS), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sys_rst_pulse(sys_rst_pulse), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (sys_rst_pulse) pcount <= pcount + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); t_wr = cyc; wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rd_data; rd_en = 0;
  endtask

  task automatic wait_out(input bit want_irq, input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (want_irq ? irq : sys_rst_pulse) begin at = cyc; break; end
    end
  endtask

  task automatic quiet();
    wr(8'h18, MKEY);
    wr(8'h14, MKEY | 32'd1);
    wr(8'h10, RESTART);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pulse", sys_rst_pulse, 0);
    chk("R1 irq", irq, 0);
    rd(8'h18, d); chk("R1 mode", d, 0);
    rd(8'h14, d); chk("R1 action", d, 1);
    rd(8'h10, d); chk("R11 ctrl reads 0", d, 0);
  endtask

  task automatic t_mode_key();
    logic [31:0] d;
    wr(8'h18, MKEY | 32'h50);
    rd(8'h18, d); chk("R2/R11 keyed mode", d, 32'h50);
    wr(8'h18, 32'h71);
    rd(8'h18, d); chk("R2 unkeyed mode ignored", d, 32'h50);
    wr(8'h18, 32'h16AB0071);
    rd(8'h18, d); chk("R2 near-key ignored", d, 32'h50);
    wr(8'h18, MKEY);
  endtask

  task automatic t_act_key();
    logic [31:0] d;
    wr(8'h14, 32'h2);
    rd(8'h14, d); chk("R3 unkeyed action ignored", d, 1);
    wr(8'h14, MKEY | 32'h2);
    rd(8'h14, d); chk("R3/R11 keyed action", d, 2);
    quiet();
  endtask

  task automatic t_table();
    int codes[5] = '{0, 3, 7, 11, 13};
    int units[5] = '{1, 6, 16, 32, 32};
    int at;
    foreach (codes[k]) begin
      quiet();
      wr(8'h18, MKEY | (codes[k] << 4) | 32'd1);
      at = t_wr;
      wait_out(0, units[k] * UNIT + 20, at);
      chk(codes[k] >= 12 ? "R6 reserved code period" : "R5 code period",
          at - t_wr, units[k] * UNIT);
    end
    quiet();
  endtask

  task automatic t_pulse();
    int at, at2;
    wr(8'h18, MKEY | 32'd1);
    wait_out(0, UNIT + 20, at);
    chk("R7 first pulse", at - t_wr, UNIT);
    @(negedge clk); chk("R7 single cycle", sys_rst_pulse, 0);
    wait_out(0, UNIT + 20, at2);
    chk("R7 repeat period", at2 - at, UNIT);
    quiet();
  endtask

  task automatic t_irq();
    int at, p0;
    wr(8'h14, MKEY | 32'd2);
    p0 = pcount;
    wr(8'h18, MKEY | 32'd1);
    wait_out(1, UNIT + 20, at);
    chk("R8 irq time", at - t_wr, UNIT);
    repeat (UNIT + 200) @(negedge clk);
    chk("R8 irq sticky", irq, 1);
    chk("R8 no reset pulse", pcount - p0, 0);
    wr(8'h10, 32'h14AE);
    chk("R4 restart without bit0 keeps irq", irq, 1);
    wr(8'h10, RESTART);
    chk("R8 keyed restart clears irq", irq, 0);
    quiet();
  endtask

  task automatic t_disable();
    int p0;
    wr(8'h18, MKEY | 32'd1);
    repeat (500) @(negedge clk);
    wr(8'h18, MKEY);
    p0 = pcount;
    repeat (3 * UNIT) @(negedge clk);
    chk("R9 no pulse while disabled", pcount - p0, 0);
    chk("R9 no irq while disabled", irq, 0);
  endtask

  task automatic t_code_change();
    int at;
    wr(8'h18, MKEY | 32'h11);
    repeat (1500) @(negedge clk);
    wr(8'h18, MKEY | 32'h01);
    wait_out(0, 2 * UNIT, at);
    chk("R10 code change restarts", at - t_wr, UNIT);
    quiet();
  endtask

  task automatic t_restart_key();
    int at, t0;
    wr(8'h18, MKEY | 32'd1);
    t0 = t_wr;
    repeat (600) @(negedge clk);
    wr(8'h10, 32'h000014B1);
    wr(8'h10, 32'h000014AE);
    wait_out(0, UNIT, at);
    chk("R4 bad restart ignored", at - t0, UNIT);
    repeat (300) @(negedge clk);
    wr(8'h10, RESTART);
    wait_out(0, UNIT + 20, at);
    chk("R4 keyed restart", at - t_wr, UNIT);
    quiet();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode_key();
    t_act_key();
    t_pulse();
    t_irq();
    t_disable();
    t_code_change();
    t_restart_key();
    t_table();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule